// File: doc/BRIEF.md
# Run-Recency Detector

This block watches a serial bit stream, one sample per clock edge, for two kinds of event: three equal samples of 0 in a row, and three equal samples of 1 in a row. A single output flag reports which kind of event happened last. The flag is 1 when the latest event was a run of zeros. It is 0 when the latest event was a run of ones, and also when no event has happened since reset.

The design is a Moore machine, so the flag comes straight from a register. It changes only at the clock edge that takes the third matching sample of a run. Between events it holds its value, whatever the input does, for as long as no new event occurs.

Top module: `run_recency_det`

## Requirements
- R1: A synchronous active-high reset drives z to 0 at the next edge and discards any partial run. The first sample taken after reset always starts a new run of length one.
- R2: At the edge that takes the third consecutive sample with x=0, z becomes 1 and is visible right after that edge.
- R3: At the edge that takes the third consecutive sample with x=1, z becomes 0 and is visible right after that edge.
- R4: A run of only one or two equal samples leaves z unchanged.
- R5: A sample that differs from the previous sample starts a new run of length one. So 0,0,1,0,0 raises no event, and 0,0,0,1,1,1 leaves z at 0.
- R6: Each sample beyond the third in a run repeats the same event, and z keeps its value.
- R7: z changes at no edge other than one that completes a run of three equal samples. It holds its value across any input that lacks such a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; x is sampled on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial input sample |
| z | output | 1 | 1 when the last run of three was zeros |

## Verification
Every result of this block is due one edge after its cause. The output that follows the third matching sample appears after the edge that takes that sample, and the cleared output appears after the first edge that sees reset high. The bench changes x two nanoseconds after a rising edge. It updates its model at the edge and compares z two nanoseconds after the same edge, so each comparison covers exactly one new sample. The stimulus mixes directed patterns with random runs biased toward repeats, so events of both kinds, broken runs and long runs all occur.

// File: rtl/run_recency_det.sv
module run_recency_det (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  localparam int unsigned RUN_LEN = 3;
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic          have_prev;
  logic          prev_bit;
  logic [CW-1:0] run_len;
  logic          last_zero;

  logic          same;
  logic [CW-1:0] len_nxt;
  logic          hit;

  assign same    = have_prev && (x == prev_bit);
  assign len_nxt = !same ? CW'(1) : (run_len == FULL ? run_len : run_len + CW'(1));
  assign hit     = (len_nxt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      run_len   <= '0;
      last_zero <= 1'b0;
    end else begin
      have_prev <= 1'b1;
      prev_bit  <= x;
      run_len   <= len_nxt;
      if (hit) last_zero <= ~x;
    end
  end

  assign z = last_zero;
endmodule

module run_recency_chk (
  input logic clk,
  input logic rst,
  input logic x,
  input logic z
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk) $past(rst) |-> !z);

  // R2
  a_r2_rise_after_zeros: assert property (@(posedge clk) disable iff (rst)
    $rose(z) |-> (!$past(rst) && !$past(rst,2) && !$past(rst,3) &&
                  !$past(x) && !$past(x,2) && !$past(x,3)));

  // R3
  a_r3_fall_after_ones: assert property (@(posedge clk) disable iff (rst)
    ($fell(z) && !$past(rst)) |-> (!$past(rst,2) && !$past(rst,3) &&
                                   $past(x) && $past(x,2) && $past(x,3)));

  // R7
  a_r7_hold_without_run: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (($past(x) != $past(x,2)) || ($past(x,2) != $past(x,3))))
      |-> $stable(z));

  // R6
  a_r6_run_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst,2) && !$past(rst,3) &&
     ($past(x) == $past(x,2)) && ($past(x,2) == $past(x,3)))
      |-> (z == !$past(x)));
endmodule

bind run_recency_det run_recency_chk u_chk (.clk(clk), .rst(rst), .x(x), .z(z));

// File: tb/test_run_recency_det.sv
module test_run_recency_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic z;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit m_valid = 0;
  bit m_prev  = 0;
  int m_cnt   = 0;
  bit m_z     = 0;
  bit m_hit   = 0;

  run_recency_det i_run_recency_det (.clk(clk), .rst(rst), .x(x), .z(z));

  always #4 clk = ~clk;

  function automatic void model_step(input bit xv);
    bit same;
    same   = m_valid && (xv == m_prev);
    m_cnt  = same ? ((m_cnt < 3) ? m_cnt + 1 : 3) : 1;
    m_valid = 1;
    m_prev = xv;
    m_hit  = (m_cnt == 3);
    if (m_hit) m_z = !xv;
  endfunction

  task automatic check(input string tag);
    compared++;
    if (z !== m_z) begin
      mismatched++;
      $display("FAIL %s: z=%b expected=%b at %0t", tag, z, m_z, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    m_valid = 0; m_cnt = 0; m_z = 0;
    #2;
    rst = 1'b0;
    check("R1");
  endtask

  task automatic step(input bit xv, input string tag);
    x = xv;
    @(posedge clk);
    model_step(xv);
    #2;
    check(tag);
  endtask

  task automatic rstep(input bit xv);
    x = xv;
    @(posedge clk);
    model_step(xv);
    #2;
    if (m_hit) check(xv ? "R3" : "R2");
    else check("R7");
  endtask

  initial begin
    bit cur;
    @(posedge clk); #2;
    do_reset();
    step(0, "R4"); step(0, "R4"); step(0, "R2");
    step(0, "R6"); step(0, "R6");
    step(1, "R4"); step(1, "R4"); step(0, "R5"); step(1, "R5");
    step(1, "R4"); step(1, "R3"); step(1, "R6");
    step(0, "R5"); step(0, "R4"); step(1, "R5"); step(0, "R5"); step(0, "R5");
    step(0, "R2");
    step(1, "R5"); step(1, "R5"); step(1, "R3");
    step(0, "R4"); step(0, "R4");
    do_reset();
    step(0, "R1"); step(0, "R1");
    step(1, "R5"); step(0, "R7"); step(1, "R7"); step(0, "R7");
    step(0, "R4"); step(0, "R2");
    step(1, "R4"); step(0, "R7"); step(1, "R7"); step(1, "R4");
    x = 0;
    rst = 1'b1;
    @(posedge clk);
    m_valid = 0; m_cnt = 0; m_z = 0;
    #2;
    rst = 1'b0;
    check("R1");
    step(1, "R1"); step(1, "R1"); step(1, "R3");
    void'($urandom(32'd20240611));
    cur = 0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) cur = !cur;
      rstep(cur);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule